// File: doc/BRIEF.md
# Tone Generator Volume Envelope Sequencer

This block plays volume envelopes on the three channels of a programmable tone generator. An envelope is a table in a byte-wide ROM. The table is a run of two-byte entries: a volume byte, then a hold-length byte. When a channel is started with a table base address, the sequencer reads the first entry at once and writes its volume to that channel's volume register. It then holds that volume for the given number of tick strobes before it reads the next entry.

The three channels run independently. Each channel has its own table pointer and its own hold counter. All three share one synchronous ROM read port, which is granted round-robin. Each fetch produces one register write, so writes from different channels never overlap. The table pointer advances only within its 256-byte page.

Top module: `env_seq`

## Requirements
- R1: While `rstN` is low, and in the cycle after it is released, `regWe` and `romRd` are low. No channel fetches until it has been started.
- R2: A fetch reads two bytes, the volume byte first and then the length byte, in two consecutive `romRd` cycles. The ROM returns on `romData` the byte for the address presented with `romRd` one cycle earlier. The volume write is strobed two cycles after the length read.
- R3: A length L from 1 to 255 holds the volume for L ticks. The next volume write follows the L-th tick after the write. Ticks that arrive while a fetch is pending are not counted.
- R4: A length byte of 0 gives the same hold as a length of 1, which is one tick.
- R5: Each write goes to register address 0x08 plus the channel number (0 to 2). Its data is the low 4 bits of the volume byte, with bits 7:4 zero.
- R6: The pointer advances by incrementing only its low 8 bits, with wrap, and the high byte never changes. The length byte at an in-page offset of 0xFF is therefore read from offset 0x00 of the same page.
- R7: The channels run in parallel, each with its own pointer and hold counter. Every write strobe lasts exactly one cycle, and there is never a write in two consecutive cycles.
- R8: A newly started channel writes its first volume without waiting for any tick. If the start is sampled at edge n and the ROM port is idle, `regWe` is high after edge n+4.
- R9: The ROM port is granted round-robin, starting from channel 0 after reset. Each grant occupies 4 cycles. Channels started together therefore write in the order 0, 1, 2, at edges n+4, n+8 and n+12.
- R10: A start on a running channel reloads the pointer from the new base and cancels any fetch that channel has in flight. Its next write is the first volume of the new table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 3 | Per-channel start strobe |
| baseAddr | input | 48 | Per-channel table base; channel c uses bits [16c+15:16c] |
| tick | input | 1 | Hold-time tick strobe |
| romAddr | output | 16 | ROM read address |
| romRd | output | 1 | ROM read request |
| romData | input | 8 | ROM read data, one cycle after the request |
| regWe | output | 1 | Register write strobe |
| regAddr | output | 8 | Register address |
| regData | output | 8 | Register write data |

## Verification
The assertions take for granted that the ROM answers every read in the following cycle. They also assume `rstN` is held low for at least two cycles. The register-write checks further assume that starts and ticks are single-cycle pulses. The bench's ROM model always answers with a one-cycle latency. The bench spaces ticks 20 cycles apart, which is longer than three back-to-back 4-cycle fetches, so every hold is fully fetched before the next tick arrives. It also issues starts only just after a tick.

// File: rtl/env_seq_pkg.sv
package env_seq_pkg;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_RD_VOL,
    FS_RD_LEN,
    FS_COMMIT
  } fetchState_t;

  // strobes from the fetch control to the datapath
  typedef struct packed {
    logic rdVol;   // volume byte address on the ROM port
    logic rdLen;   // length byte address on the ROM port, volume byte arriving
    logic commit;  // length byte arriving, finish the entry
  } fetchStrobe_t;

endpackage

// File: rtl/env_seq_ctrl.sv
module env_seq_ctrl
  import env_seq_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int SEL_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_CH-1:0]  needFetch,
  input  logic [NUM_CH-1:0]  start,
  output fetchStrobe_t       strobe,
  output logic [SEL_W-1:0]   sel
);

  fetchState_t      state;
  logic [SEL_W-1:0] lastGrant;
  logic [SEL_W-1:0] pick;
  logic             pickValid;
  logic             selRestart;

  // round-robin search starting after the last granted channel
  always_comb begin
    int idx;
    pickValid = 1'b0;
    pick      = lastGrant;
    for (int i = 1; i <= NUM_CH; i++) begin
      idx = (int'(lastGrant) + i) % NUM_CH;
      if (!pickValid && needFetch[idx]) begin
        pickValid = 1'b1;
        pick      = SEL_W'(idx);
      end
    end
  end

  assign selRestart = start[sel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= FS_IDLE;
      sel       <= '0;
      lastGrant <= SEL_W'(NUM_CH - 1);
    end else begin
      case (state)
        FS_IDLE: begin
          if (pickValid) begin
            sel       <= pick;
            lastGrant <= pick;
            state     <= FS_RD_VOL;
          end
        end
        FS_RD_VOL: state <= selRestart ? FS_IDLE : FS_RD_LEN;
        FS_RD_LEN: state <= selRestart ? FS_IDLE : FS_COMMIT;
        default:   state <= FS_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.rdVol  = (state == FS_RD_VOL);
    strobe.rdLen  = (state == FS_RD_LEN);
    strobe.commit = (state == FS_COMMIT) && !selRestart;
  end

endmodule

// File: rtl/env_seq_dp.sv
module env_seq_dp
  import env_seq_pkg::*;
#(
  parameter int                  NUM_CH       = 3,
  parameter int                  ADDR_W       = 16,
  parameter int                  PAGE_W       = 8,
  parameter int                  DATA_W       = 8,
  parameter int                  VOL_W        = 4,
  parameter int                  REG_ADDR_W   = 8,
  parameter logic [REG_ADDR_W-1:0] VOL_REG_BASE = 8'h08,
  parameter int                  SEL_W        = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        start,
  input  logic [NUM_CH*ADDR_W-1:0] baseAddr,
  input  logic                     tick,
  input  fetchStrobe_t             strobe,
  input  logic [SEL_W-1:0]         sel,
  input  logic [DATA_W-1:0]        romData,
  output logic [ADDR_W-1:0]        romAddr,
  output logic                     romRd,
  output logic [NUM_CH-1:0]        needFetch,
  output logic                     regWe,
  output logic [REG_ADDR_W-1:0]    regAddr,
  output logic [DATA_W-1:0]        regData
);

  localparam int HI_W = ADDR_W - PAGE_W;

  logic [ADDR_W-1:0] ptr    [NUM_CH];
  logic [DATA_W-1:0] hold   [NUM_CH];
  logic              pend   [NUM_CH];
  logic              active [NUM_CH];
  logic [VOL_W-1:0]  volLatch;
  logic [ADDR_W-1:0] selPtr;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ptr[g]    <= '0;
        hold[g]   <= '0;
        pend[g]   <= 1'b0;
        active[g] <= 1'b0;
      end else if (start[g]) begin
        ptr[g]    <= baseAddr[g*ADDR_W +: ADDR_W];
        pend[g]   <= 1'b1;
        active[g] <= 1'b1;
      end else if (strobe.commit && sel == SEL_W'(g)) begin
        ptr[g]  <= {ptr[g][ADDR_W-1:PAGE_W], ptr[g][PAGE_W-1:0] + PAGE_W'(2)};
        hold[g] <= (romData == '0) ? DATA_W'(1) : romData;
        pend[g] <= 1'b0;
      end else if (tick && active[g] && !pend[g]) begin
        if (hold[g] == DATA_W'(1)) pend[g] <= 1'b1;
        else                       hold[g] <= hold[g] - 1'b1;
      end
    end
    assign needFetch[g] = pend[g];
  end

  // ROM port: volume byte at the pointer, length byte at the next in-page offset
  assign selPtr  = ptr[sel];
  assign romAddr = {selPtr[ADDR_W-1:ADDR_W-HI_W], selPtr[PAGE_W-1:0] + PAGE_W'(strobe.rdLen)};
  assign romRd   = strobe.rdVol | strobe.rdLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) volLatch <= '0;
    else if (strobe.rdLen) volLatch <= romData[VOL_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regWe   <= 1'b0;
      regAddr <= '0;
      regData <= '0;
    end else begin
      regWe <= strobe.commit;
      if (strobe.commit) begin
        regAddr <= VOL_REG_BASE + REG_ADDR_W'(sel);
        regData <= {{(DATA_W-VOL_W){1'b0}}, volLatch};
      end
    end
  end

endmodule

// File: rtl/env_seq.sv
module env_seq
  import env_seq_pkg::*;
#(
  parameter int                    NUM_CH       = 3,
  parameter int                    ADDR_W       = 16,
  parameter int                    PAGE_W       = 8,
  parameter int                    DATA_W       = 8,
  parameter int                    VOL_W        = 4,
  parameter int                    REG_ADDR_W   = 8,
  parameter logic [REG_ADDR_W-1:0] VOL_REG_BASE = 8'h08
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        start,
  input  logic [NUM_CH*ADDR_W-1:0] baseAddr,
  input  logic                     tick,
  output logic [ADDR_W-1:0]        romAddr,
  output logic                     romRd,
  input  logic [DATA_W-1:0]        romData,
  output logic                     regWe,
  output logic [REG_ADDR_W-1:0]    regAddr,
  output logic [DATA_W-1:0]        regData
);

  localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  fetchStrobe_t      strobe;
  logic [SEL_W-1:0]  sel;
  logic [NUM_CH-1:0] needFetch;

  env_seq_ctrl #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .needFetch(needFetch),
    .start    (start),
    .strobe   (strobe),
    .sel      (sel)
  );

  env_seq_dp #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W),
    .VOL_W(VOL_W), .REG_ADDR_W(REG_ADDR_W), .VOL_REG_BASE(VOL_REG_BASE), .SEL_W(SEL_W)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .baseAddr (baseAddr),
    .tick     (tick),
    .strobe   (strobe),
    .sel      (sel),
    .romData  (romData),
    .romAddr  (romAddr),
    .romRd    (romRd),
    .needFetch(needFetch),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regData  (regData)
  );

endmodule

// File: rtl/env_seq_chk.sv
module env_seq_chk #(
  parameter int                    NUM_CH       = 3,
  parameter int                    ADDR_W       = 16,
  parameter int                    PAGE_W       = 8,
  parameter int                    REG_ADDR_W   = 8,
  parameter logic [REG_ADDR_W-1:0] VOL_REG_BASE = 8'h08
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [ADDR_W-1:0]     romAddr,
  input logic                  romRd,
  input logic                  regWe,
  input logic [REG_ADDR_W-1:0] regAddr
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) $rose(rstN) |-> !regWe && !romRd);

  // R2
  write_after_reads_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> !$past(romRd) && $past(romRd, 2));

  // R6
  page_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    romRd && $past(romRd) |->
      romAddr[ADDR_W-1:PAGE_W] == $past(romAddr[ADDR_W-1:PAGE_W]) &&
      romAddr[PAGE_W-1:0] == $past(romAddr[PAGE_W-1:0]) + PAGE_W'(1));

  // R5
  reg_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> regAddr >= VOL_REG_BASE && regAddr < VOL_REG_BASE + REG_ADDR_W'(NUM_CH));

  // R7
  write_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe);

endmodule

bind env_seq env_seq_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W),
  .REG_ADDR_W(REG_ADDR_W), .VOL_REG_BASE(VOL_REG_BASE)
) i_chk (
  .clk    (clk),
  .rstN   (rstN),
  .romAddr(romAddr),
  .romRd  (romRd),
  .regWe  (regWe),
  .regAddr(regAddr)
);

// File: tb/test_env_seq.sv
module test_env_seq;

  localparam int NUM_CH   = 3;
  localparam int ADDR_W   = 16;
  localparam int TICK_GAP = 20;
  localparam int ENTRIES  = 8;
  localparam int LOG_MAX  = 64;

  logic                     clk = 1'b0;
  logic                     rstN = 1'b0;
  logic [NUM_CH-1:0]        start = '0;
  logic [NUM_CH*ADDR_W-1:0] baseAddr = '0;
  logic                     tick = 1'b0;
  logic [ADDR_W-1:0]        romAddr;
  logic                     romRd;
  logic [7:0]               romData = '0;
  logic                     regWe;
  logic [7:0]               regAddr;
  logic [7:0]               regData;

  logic [7:0] romImg [0:511];
  int cyc = 0, tickCount = 0, errors = 0, checks = 0, badAddr = 0, startCyc = 0;
  int logCnt [NUM_CH];
  logic [7:0] logData [NUM_CH][LOG_MAX];
  int logTick [NUM_CH][LOG_MAX];
  int logCyc  [NUM_CH][LOG_MAX];
  int monCh;

  env_seq i_env_seq (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr), .tick(tick),
    .romAddr(romAddr), .romRd(romRd), .romData(romData),
    .regWe(regWe), .regAddr(regAddr), .regData(regData)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) if (romRd) romData <= romImg[romAddr[8:0]];

  initial for (int c = 0; c < NUM_CH; c++) logCnt[c] = 0;

  always @(negedge clk) begin
    if (rstN && regWe) begin
      monCh = int'(regAddr) - 8;
      if (monCh < 0 || monCh >= NUM_CH) badAddr++;
      else if (logCnt[monCh] < LOG_MAX) begin
        logData[monCh][logCnt[monCh]] = regData;
        logTick[monCh][logCnt[monCh]] = tickCount;
        logCyc[monCh][logCnt[monCh]]  = cyc;
        logCnt[monCh]++;
      end
    end
  end

  function automatic logic [15:0] baseOf(input int c);
    case (c)
      0:       return 16'h0020;
      1:       return 16'h0060;
      default: return 16'h01F8;
    endcase
  endfunction
  function automatic logic [7:0] volOf(input int c, input int k);
    return 8'((k * 37 + c * 71 + 'h93) & 'hFF);
  endfunction
  function automatic logic [7:0] lenOf(input int c, input int k);
    return 8'((k + 2 * c) % 4);
  endfunction
  function automatic int effLen(input logic [7:0] l);
    return (l == 0) ? 1 : int'(l);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic putEntry(input logic [15:0] base, input int k, input logic [7:0] v, input logic [7:0] l);
    logic [7:0] lo;
    lo = base[7:0] + 8'(2 * k);
    romImg[{base[8], lo}] = v;
    lo = lo + 8'd1;
    romImg[{base[8], lo}] = l;
  endtask

  task automatic runTicks(input int n);
    for (int i = 0; i < n; i++) begin
      repeat (TICK_GAP - 1) @(negedge clk);
      tick = 1'b1;
      tickCount++;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  initial begin
    for (int a = 0; a < 512; a++) romImg[a] = 8'h00;
    for (int c = 0; c < NUM_CH; c++)
      for (int k = 0; k < ENTRIES; k++) putEntry(baseOf(c), k, volOf(c, k), lenOf(c, k));
    putEntry(16'h0080, 0, 8'h4C, 8'd1);
    putEntry(16'h0080, 1, 8'h23, 8'd2);
    putEntry(16'h0080, 2, 8'h9E, 8'd0);

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: quiet after reset with no start
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!regWe && !romRd, "R1 idle after reset", {regWe, romRd}, 0);
    end

    // all three channels started together
    @(negedge clk);
    baseAddr = {baseOf(2), baseOf(1), baseOf(0)};
    start    = '1;
    startCyc = cyc;
    @(negedge clk);
    start = '0;
    runTicks(30);

    for (int c = 0; c < NUM_CH; c++) begin
      check(logCnt[c] >= ENTRIES, "R7 parallel channel write count", logCnt[c], ENTRIES);
      if (logCnt[c] >= ENTRIES) begin
        // R8 first write without a tick; R9 round-robin order
        check(logCyc[c][0] == startCyc + 5 + 4 * c, (c == 0) ? "R8 first write latency" : "R9 grant order latency",
              logCyc[c][0] - startCyc, 5 + 4 * c);
        for (int k = 0; k < ENTRIES; k++) begin
          check(logData[c][k] == {4'h0, volOf(c, k)[3:0]},
                (c == 2 && k >= 4) ? "R6 wrapped entry data" : "R2 R5 volume data",
                logData[c][k], {4'h0, volOf(c, k)[3:0]});
          if (k > 0)
            check(logTick[c][k] - logTick[c][k-1] == effLen(lenOf(c, k - 1)),
                  (lenOf(c, k - 1) == 0) ? "R4 zero length hold" : "R3 hold ticks",
                  logTick[c][k] - logTick[c][k-1], effLen(lenOf(c, k - 1)));
        end
      end
    end
    check(badAddr == 0, "R5 register address range", badAddr, 0);

    // R10 restart channel 1 on a new table
    begin
      int prev, tBase;
      prev  = logCnt[1];
      tBase = tickCount;
      @(negedge clk);
      baseAddr[31:16] = 16'h0080;
      start = 3'b010;
      @(negedge clk);
      start = '0;
      runTicks(6);
      check(logCnt[1] >= prev + 3, "R10 restart write count", logCnt[1] - prev, 3);
      if (logCnt[1] >= prev + 3) begin
        check(logData[1][prev] == 8'h0C, "R10 restart first volume", logData[1][prev], 8'h0C);
        check(logTick[1][prev] == tBase, "R10 restart without tick", logTick[1][prev] - tBase, 0);
        check(logData[1][prev+1] == 8'h03, "R10 restart second volume", logData[1][prev+1], 8'h03);
        check(logTick[1][prev+1] - logTick[1][prev] == 1, "R3 restart hold", logTick[1][prev+1] - logTick[1][prev], 1);
        check(logData[1][prev+2] == 8'h0E, "R5 restart third volume", logData[1][prev+2], 8'h0E);
        check(logTick[1][prev+2] - logTick[1][prev+1] == 2, "R3 restart hold two", logTick[1][prev+2] - logTick[1][prev+1], 2);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule